// File: doc/BRIEF.md
# Inactivity Powerdown Controller

This block holds the power-management state of a multi-channel serial line interface. It watches the logic-level transmitter inputs and the digitized receiver inputs for edges. From these edges and two control pins it decides when the charge pump and the line drivers run. The control pins are an active-low force-off and an active-high force-on. With force-off released and force-on low, a period with no activity on any watched line lets the interface fall asleep. The next edge wakes it again.

The block also drives the rest of the interface's control. It gives the tri-state control for the drivers and for the standard receiver outputs. It passes one receiver channel through as a monitor output that never turns off. It raises a ready flag once the negative supply rail reports that it has reached its working level. The inactivity timeout and the wake-up delay are parameters counted in clock cycles. Every asynchronous input passes through a two-flop synchronizer. An edge is any difference between two consecutive synchronized samples.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: During and after reset the charge pump enable, the driver enable and ready are low, and the idle timer starts in its expired state. With no input edge after reset, the block therefore stays powered down.
- R2: A change on any transmitter or receiver input, with force-off high, makes the charge pump enable rise no more than 4 clock cycles after the input changes.
- R3: The driver enable rises WAKE_CYCLES cycles after the charge pump enable rises. It is low whenever the charge pump enable is low.
- R4: Ready is high only while the charge pump runs and the synchronized rail flag has been seen high since power-up. Ready falls on the same clock edge as the charge pump enable.
- R5: With force-off high and force-on low, TIMEOUT_CYCLES cycles with no input edge switch off the charge pump and the drivers.
- R6: The standard receiver enable is high whenever the synchronized force-off pin is high, which includes automatic powerdown.
- R7: Once the idle timer has expired, it stays expired and the block stays down until an input edge arrives or force-on goes high.
- R8: Force-on high with force-off high keeps the block powered for any length of time. A rising force-on wakes a block that is down.
- R9: After force-on falls, the block stays powered for a full TIMEOUT_CYCLES period even when no input edge occurs.
- R10: Force-off low powers the block down within 5 cycles, whatever force-on does. It also drives the standard receiver enable low and ready low. Input edges while force-off is low do not wake the block.
- R11: When force-off returns high with force-on low, the block stays down until an input edge occurs.
- R12: The monitor output equals receiver input MON_IDX delayed by the two synchronizer stages. This holds in every power state, including the force-off powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txIn | input | NUM_TX | Logic-level transmitter inputs, watched for edges |
| rxIn | input | NUM_RX | Digitized receiver inputs, watched for edges |
| forceOffN | input | 1 | Active-low forced powerdown, overrides every other input |
| forceOn | input | 1 | Active-high hold-awake, disables the inactivity powerdown |
| negRailOk | input | 1 | Negative rail has reached its ready level |
| pumpEn | output | 1 | Charge pump enable |
| txDrvEn | output | 1 | Line driver enable (low means high impedance) |
| rxOutEn | output | 1 | Standard receiver output enable |
| monRxOut | output | 1 | Always-active monitor copy of receiver MON_IDX |
| ready | output | 1 | Interface ready to transmit |

## Verification
A wrong idle-timer state shows at the ports in one of two ways. If the expiry flag is lost, the block wakes with no edge, and the charge pump enable rises within a few cycles of the fault. If the expiry flag is set too early, the pump drops well before TIMEOUT_CYCLES has passed. A wrong power state shows at once as a driver enable or ready without a running charge pump. A misrouted force-off shows as receiver outputs that turn off in automatic powerdown. The bench therefore samples on both sides of every timing window: the timeout, the wake delay, the force-on fall and the release of force-off.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

  // Strobes the datapath hands to the control each cycle.
  typedef struct packed {
    logic edgeSeen;     // a watched line changed between two synced samples
    logic forceOnHi;    // synchronized hold-awake pin
    logic manualOff;    // synchronized forced powerdown active
    logic railOk;       // synchronized negative rail flag
    logic idleExpired;  // inactivity timer in its expired state
  } ipdStat_t;

  typedef enum logic [1:0] {
    PWR_DOWN = 2'd0,
    PWR_WAKE = 2'd1,
    PWR_UP   = 2'd2
  } pwrState_t;

endpackage

// File: rtl/idle_pwr_sync.sv
module idle_pwr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/idle_pwr_datapath.sv
module idle_pwr_datapath
  import idle_pwr_pkg::*;
#(
  parameter int NUM_TX         = 2,
  parameter int NUM_RX         = 3,
  parameter int MON_IDX        = 1,
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TX-1:0] txIn,
  input  logic [NUM_RX-1:0] rxIn,
  input  logic              forceOffN,
  input  logic              forceOn,
  input  logic              negRailOk,
  output ipdStat_t          stat,
  output logic              monRxOut
);
  localparam int LINE_W = NUM_TX + NUM_RX;
  localparam int SYNC_W = LINE_W + 3;
  localparam int CNT_W  = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [SYNC_W-1:0] rawVec;
  logic [SYNC_W-1:0] syncVec;
  logic [LINE_W-1:0] lineNow;
  logic [LINE_W-1:0] linePrev;
  logic [NUM_RX-1:0] rxNow;
  logic              fonNow;
  logic              foffNow;
  logic              railNow;
  logic              edgeAny;
  logic [CNT_W-1:0]  idleCnt;
  logic              expired;

  assign rawVec = {negRailOk, forceOn, forceOffN, rxIn, txIn};

  idle_pwr_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rawVec),
    .q    (syncVec)
  );

  assign lineNow = syncVec[LINE_W-1:0];
  assign rxNow   = syncVec[LINE_W-1:NUM_TX];
  assign foffNow = syncVec[LINE_W];
  assign fonNow  = syncVec[LINE_W+1];
  assign railNow = syncVec[LINE_W+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) linePrev <= '0;
    else        linePrev <= lineNow;
  end

  assign edgeAny = |(lineNow ^ linePrev);

  // Inactivity timer: force-off sets it, force-on or an edge clears it,
  // otherwise it counts to the limit and then holds expired.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
      expired <= 1'b1;
    end else if (!foffNow) begin
      idleCnt <= '0;
      expired <= 1'b1;
    end else if (fonNow || edgeAny) begin
      idleCnt <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (idleCnt == CNT_LAST) expired <= 1'b1;
      else                     idleCnt <= idleCnt + 1'b1;
    end
  end

  assign stat.edgeSeen    = edgeAny;
  assign stat.forceOnHi   = fonNow;
  assign stat.manualOff   = !foffNow;
  assign stat.railOk      = railNow;
  assign stat.idleExpired = expired;

  assign monRxOut = rxNow[MON_IDX];
endmodule

// File: rtl/idle_pwr_ctrl_fsm.sv
module idle_pwr_ctrl_fsm
  import idle_pwr_pkg::*;
#(
  parameter int WAKE_CYCLES = 100
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ipdStat_t stat,
  output logic     pumpEn,
  output logic     txDrvEn,
  output logic     rxOutEn,
  output logic     ready
);
  localparam int WK_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYCLES - 1);

  pwrState_t       state;
  pwrState_t       stateNxt;
  logic [WK_W-1:0] wakeCnt;
  logic            wakeDone;
  logic            wantOn;
  logic            readyReg;

  assign wantOn   = !stat.manualOff && !stat.idleExpired;
  assign wakeDone = (wakeCnt == WK_LAST);

  always_comb begin
    stateNxt = state;
    case (state)
      PWR_DOWN: if (wantOn) stateNxt = PWR_WAKE;
      PWR_WAKE: begin
        if (!wantOn)       stateNxt = PWR_DOWN;
        else if (wakeDone) stateNxt = PWR_UP;
      end
      PWR_UP:   if (!wantOn) stateNxt = PWR_DOWN;
      default:  stateNxt = PWR_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PWR_DOWN;
      wakeCnt  <= '0;
      readyReg <= 1'b0;
    end else begin
      state    <= stateNxt;
      if (state != PWR_WAKE) wakeCnt <= '0;
      else if (!wakeDone)    wakeCnt <= wakeCnt + 1'b1;
      readyReg <= (stateNxt != PWR_DOWN) && (readyReg || stat.railOk);
    end
  end

  assign pumpEn  = (state != PWR_DOWN);
  assign txDrvEn = (state == PWR_UP);
  assign rxOutEn = !stat.manualOff;
  assign ready   = readyReg;
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pwr_pkg::*;
#(
  parameter int NUM_TX         = 2,
  parameter int NUM_RX         = 3,
  parameter int MON_IDX        = 1,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int WAKE_CYCLES    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TX-1:0] txIn,
  input  logic [NUM_RX-1:0] rxIn,
  input  logic              forceOffN,
  input  logic              forceOn,
  input  logic              negRailOk,
  output logic              pumpEn,
  output logic              txDrvEn,
  output logic              rxOutEn,
  output logic              monRxOut,
  output logic              ready
);
  ipdStat_t dpStat;

  idle_pwr_datapath #(
    .NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .MON_IDX(MON_IDX),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .txIn(txIn), .rxIn(rxIn),
    .forceOffN(forceOffN), .forceOn(forceOn), .negRailOk(negRailOk),
    .stat(dpStat), .monRxOut(monRxOut)
  );

  idle_pwr_ctrl_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stat(dpStat),
    .pumpEn(pumpEn), .txDrvEn(txDrvEn), .rxOutEn(rxOutEn), .ready(ready)
  );
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk
  import idle_pwr_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     pumpEn,
  input logic     txDrvEn,
  input logic     rxOutEn,
  input logic     ready,
  input ipdStat_t stat
);
  assert_tx_needs_pump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pumpEn |-> !txDrvEn);

  assert_tx_after_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txDrvEn) |-> $past(pumpEn));

  assert_ready_needs_pump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pumpEn);

  assert_ready_needs_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(stat.railOk));

  assert_expired_goes_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat.idleExpired |=> !pumpEn);

  assert_rx_live_unless_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat.manualOff |-> rxOutEn);

  assert_expiry_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.idleExpired && !stat.edgeSeen && !stat.forceOnHi) |=> stat.idleExpired);

  assert_forceon_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.forceOnHi && !stat.manualOff) |=> !stat.idleExpired);

  assert_forced_off_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat.manualOff |=> (!pumpEn && stat.idleExpired));
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pumpEn(pumpEn), .txDrvEn(txDrvEn),
  .rxOutEn(rxOutEn), .ready(ready), .stat(dpStat)
);

// File: tb/idle_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_pwr_ctrl_tb_top;
  localparam int NTX  = 2;
  localparam int NRX  = 3;
  localparam int MON  = 1;
  localparam int TOUT = 200;
  localparam int WAKE = 8;

  // Output vector order: {pumpEn, txDrvEn, rxOutEn, ready, monRxOut}
  localparam logic [4:0] MP = 5'b10000;
  localparam logic [4:0] MT = 5'b01000;
  localparam logic [4:0] MR = 5'b00100;
  localparam logic [4:0] MY = 5'b00010;
  localparam logic [4:0] MO = 5'b00001;

  typedef struct {
    int         cyc;
    logic [4:0] exp;
    logic [4:0] msk;
    string      tag;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NTX-1:0] txIn = '0;
  logic [NRX-1:0] rxIn = '0;
  logic           forceOffN = 1'b1;
  logic           forceOn = 1'b0;
  logic           negRailOk = 1'b0;
  logic           pumpEn, txDrvEn, rxOutEn, monRxOut, ready;

  int       cyc = 0;
  int       checks = 0;
  int       errors = 0;
  bit       finished = 1'b0;
  expItem_t sbQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  idle_pwr_ctrl #(
    .NUM_TX(NTX), .NUM_RX(NRX), .MON_IDX(MON),
    .TIMEOUT_CYCLES(TOUT), .WAKE_CYCLES(WAKE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .txIn(txIn), .rxIn(rxIn),
    .forceOffN(forceOffN), .forceOn(forceOn), .negRailOk(negRailOk),
    .pumpEn(pumpEn), .txDrvEn(txDrvEn), .rxOutEn(rxOutEn),
    .monRxOut(monRxOut), .ready(ready)
  );

  task automatic compare(input logic [4:0] e, input logic [4:0] m, input string tag);
    logic [4:0] act;
    act = {pumpEn, txDrvEn, rxOutEn, ready, monRxOut};
    checks++;
    if (((act ^ e) & m) != 5'b0) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b", tag, cyc, act, e, m);
    end
  endtask

  // Driver side: queue an expectation d cycles from now.
  task automatic pushExp(input int d, input logic [4:0] e, input logic [4:0] m,
                         input string tag);
    expItem_t it;
    it.cyc = cyc + d; it.exp = e; it.msk = m; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    while (sbQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop every expectation whose cycle has come.
  always @(negedge clk) begin
    while (sbQ.size() != 0 && sbQ[0].cyc <= cyc) begin
      expItem_t it;
      it = sbQ.pop_front();
      compare(it.exp, it.msk, it.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    compare(5'b00000, MP | MT | MY, "R1 reset outputs low");
    rst_n = 1'b1;
    pushExp(10, 5'b00100, MP | MT | MR | MY, "R1 R6 idle after reset, no edge");
    pushExp(30, 5'b00100, MP | MT, "R1 still down later");
    drain();

    // R2/R3: transmitter edge wakes, drivers follow after wake delay
    txIn[0] = ~txIn[0];
    pushExp(3, 5'b00000, MP, "R2 pump not yet on");
    pushExp(5, 5'b10000, MP | MT, "R2 pump on after tx edge");
    pushExp(WAKE + 2, 5'b10000, MP | MT, "R3 drivers still off in wake");
    pushExp(WAKE + 6, 5'b11000, MP | MT | MY, "R3 drivers on, R4 ready low without rail");
    drain();

    // R4: rail flag raises ready
    negRailOk = 1'b1;
    pushExp(6, 5'b11010, MP | MT | MY, "R4 ready after rail flag");
    drain();

    // R5/R6: receiver edge restarts timer, then inactivity powerdown
    rxIn[2] = ~rxIn[2];
    pushExp(TOUT - 2, 5'b11010, MP | MT | MY, "R5 still up before timeout");
    pushExp(TOUT + 6, 5'b00100, MP | MT | MR | MY, "R5 R6 auto down, receivers live");
    drain();

    // R7: stays latched down; R12 monitor follows while down
    rxIn[MON] = ~rxIn[MON];
    pushExp(3, {4'b0000, rxIn[MON]}, MP | MO, "R12 monitor in auto down");
    drain();
    rxIn[MON] = ~rxIn[MON];
    drain();
    repeat (10) @(negedge clk);
    pushExp(2 * TOUT, 5'b00100, MP | MT | MR, "R7 latched down with no edge");
    drain();
    rxIn[0] = ~rxIn[0];
    pushExp(5, 5'b10000, MP, "R2 pump on after rx edge");
    pushExp(WAKE + 6, 5'b11010, MP | MT | MY, "R2 R4 fully up after rx edge");
    drain();

    // R8: force-on holds awake
    forceOn = 1'b1;
    pushExp(3 * TOUT, 5'b11110, MP | MT | MR | MY, "R8 force-on keeps powered");
    drain();

    // R9: force-on fall gives a full timeout
    forceOn = 1'b0;
    pushExp(TOUT - 2, 5'b11000, MP | MT, "R9 still up after force-on fall");
    pushExp(TOUT + 6, 5'b00000, MP | MT | MY, "R9 down after full period");
    drain();

    // R8: rising force-on wakes a down block
    forceOn = 1'b1;
    pushExp(5, 5'b10000, MP, "R8 force-on rise wakes");
    pushExp(WAKE + 6, 5'b11010, MP | MT | MY, "R8 up after force-on rise");
    drain();

    // R10: force-off overrides force-on; edges ignored
    forceOffN = 1'b0;
    pushExp(5, 5'b00000, MP | MT | MR | MY, "R10 forced down");
    drain();
    txIn[1] = ~txIn[1];
    rxIn[MON] = ~rxIn[MON];
    pushExp(3, {4'b0000, rxIn[MON]}, MO, "R12 monitor in forced down");
    pushExp(8, 5'b00000, MP | MT | MR, "R10 edges ignored while forced");
    drain();

    // R11: release with force-on low stays down until an edge
    forceOn = 1'b0;
    repeat (4) @(negedge clk);
    forceOffN = 1'b1;
    pushExp(6, 5'b00100, MP | MR, "R11 released, still down, R6 receivers on");
    pushExp(TOUT + 10, 5'b00100, MP | MT | MR, "R11 still down much later");
    drain();
    txIn[0] = ~txIn[0];
    pushExp(5, 5'b10000, MP, "R11 edge wakes after release");
    drain();

    // R12: monitor path while up
    rxIn[MON] = ~rxIn[MON];
    pushExp(3, {4'b1000, rxIn[MON]}, MP | MO, "R12 monitor while up");
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule